// File: doc/BRIEF.md
# Two-Lane Frame-Aligned ADC Sample Deserializer

This block rebuilds parallel 16-bit samples from the serial stream of one converter channel. The channel uses up to two data lanes and a frame clock. All three arrive already sampled into single bits, one bit per lane per cycle, in the fast bit-rate clock domain. Word edges are taken from the sampled frame clock. A rising transition of the frame clock marks the first bit of a new word. The register that has been shifting in bits is latched at that moment.

In single-lane mode the frame clock has one period per sample and only lane A carries data. In dual-lane word-wise mode the frame clock runs at half the sample rate. Each lane then carries complete samples during one frame: lane B carries the even-numbered sample and lane A the odd-numbered one. The block merges both lanes back into one ordered stream with a running sample index. Two further controls are provided: a bit-order select, and a polarity-invert input that corrects a swapped frame-clock pair.

An alignment flag reports that the frame clock has shown a steady period for several frames in a row.

Top module: `word_lane_deser`

## Requirements
- R1: With `mode_2w`=0, the W=16 bits of lane A received between two frame starts exactly W cycles apart are emitted as one sample. `out_valid` is high for exactly one cycle, on the clock edge that sees the next frame start.
- R2: With `lsb_first`=1, the first bit of a frame is bit 0 of the sample. With `lsb_first`=0, the first bit is bit 15.
- R3: With `mode_2w`=1, each full frame yields two samples on consecutive cycles. The lane B word comes first, on the edge that sees the next frame start. The lane A word follows one cycle later.
- R4: `out_index` is 0 on the first sample after reset and increases by one (modulo 2^16) with every emitted sample.
- R5: With `fclk_inv`=1, the frame-clock bit is inverted before edge detection, so a falling transition on `fclk_bit` starts a frame. Data results are the same as with a true-polarity clock.
- R6: A frame whose length between frame starts is not exactly W cycles produces no sample. The first frame after reset or after an idle gap also produces no sample.
- R7: `aligned` rises after 4 consecutive frame starts, each W cycles after the previous one. It clears on any frame start at another spacing, and whenever W cycles pass without a frame start.
- R8: Synchronous active-high `rst` clears the shift registers, the alignment count and the sample index. After reset, `out_valid` and `aligned` are 0.
- R9: With `mode_2w`=0, lane B has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_2w | input | 1 | 0: single lane; 1: dual-lane word-wise |
| lsb_first | input | 1 | 1: first bit of a frame is the sample LSB |
| fclk_inv | input | 1 | Invert the sampled frame clock |
| lane_a | input | 1 | Sampled data bit of lane A |
| lane_b | input | 1 | Sampled data bit of lane B |
| fclk_bit | input | 1 | Sampled frame-clock bit |
| out_valid | output | 1 | Sample strobe |
| out_data | output | 16 | Reassembled sample |
| out_index | output | 16 | Running sample number |
| aligned | output | 1 | Frame clock has been steady for 4 frames |

## Verification
The hardest situation to reach is the loss of lock in the middle of a stream. This needs a frame start that comes early while data keeps flowing. The frames next to it must still be emitted or dropped correctly. The driver takes a length for each frame and inserts a 12-cycle frame between full ones, with the polarity inverted. This checks the alignment flag before and after the short frame, the missing sample for it, and that the index is still continuous. Idle gaps between groups drop lock through the missing-edge path, which also allows mode, bit order and polarity to change safely.

// File: rtl/word_lane_deser.sv
module word_lane_deser #(
  parameter int W    = 16,
  parameter int LOCK = 4,
  parameter int IW   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_2w,
  input  logic          lsb_first,
  input  logic          fclk_inv,
  input  logic          lane_a,
  input  logic          lane_b,
  input  logic          fclk_bit,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [IW-1:0] out_index,
  output logic          aligned
);
  localparam int CW = $clog2(W + 1);
  localparam int LW = $clog2(LOCK + 1);

  logic          f_prev;
  logic [CW-1:0] bcnt;
  logic [LW-1:0] lcnt;
  logic [W-1:0]  sr_a, sr_b, hold_a;
  logic          pend;
  logic [IW-1:0] idx;

  wire f_now = fclk_bit ^ fclk_inv;
  wire rise  = f_now & ~f_prev;
  wire full  = (bcnt == CW'(W - 1));
  wire good  = rise & full;
  wire bad   = rise ^ full;

  assign aligned = (lcnt == LW'(LOCK));

  always_ff @(posedge clk) begin
    if (rst) begin
      f_prev <= 1'b0;
      bcnt   <= CW'(W);
      lcnt   <= '0;
      sr_a   <= '0;
      sr_b   <= '0;
    end else begin
      f_prev <= f_now;
      if (rise)               bcnt <= '0;
      else if (bcnt != CW'(W)) bcnt <= bcnt + 1'b1;
      if (bad)       lcnt <= '0;
      else if (good && !aligned) lcnt <= lcnt + 1'b1;
      sr_a <= lsb_first ? {lane_a, sr_a[W-1:1]} : {sr_a[W-2:0], lane_a};
      sr_b <= lsb_first ? {lane_b, sr_b[W-1:1]} : {sr_b[W-2:0], lane_b};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_index <= '0;
      hold_a    <= '0;
      pend      <= 1'b0;
      idx       <= '0;
    end else if (good) begin
      out_valid <= 1'b1;
      out_data  <= mode_2w ? sr_b : sr_a;
      out_index <= idx;
      idx       <= idx + 1'b1;
      hold_a    <= sr_a;
      pend      <= mode_2w;
    end else if (pend) begin
      out_valid <= 1'b1;
      out_data  <= hold_a;
      out_index <= idx;
      idx       <= idx + 1'b1;
      pend      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

module word_lane_deser_chk #(
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_2w,
  input logic          out_valid,
  input logic [IW-1:0] out_index,
  input logic          aligned
);
  logic          seen;
  logic [IW-1:0] pidx;
  logic          rq = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      pidx <= '0;
    end else if (out_valid) begin
      seen <= 1'b1;
      pidx <= out_index;
    end
  end

  always_ff @(posedge clk) begin
    rq <= rst;
    if (rq) begin
      AST_RESET_CLEAR: assert (!out_valid && !aligned); // R8
    end
  end

  AST_INDEX_FIRST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !seen) |-> (out_index == '0)); // R4

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seen) |-> (out_index == IW'(pidx + 1'b1))); // R4

  AST_LOCK_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> out_valid); // R7

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !mode_2w && $past(!mode_2w)) |=> !out_valid); // R1

  AST_PAIR_STROBE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(out_valid) && mode_2w && $past(mode_2w)) |=> out_valid); // R3
endmodule

bind word_lane_deser word_lane_deser_chk #(.IW(IW)) u_chk (.*);

// File: tb/tb_word_lane_deser.sv
module tb_word_lane_deser;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_2w = 1'b0, lsb_first = 1'b1, fclk_inv = 1'b0;
  logic lane_a = 1'b0, lane_b = 1'b0, fclk_bit = 1'b0;
  logic          out_valid;
  logic [W-1:0]  out_data;
  logic [15:0]   out_index;
  logic          aligned;

  int checks = 0, fails = 0;
  logic [W-1:0] q_data[$];
  string        q_tag[$];
  logic [15:0]  exp_idx = '0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  word_lane_deser dut (.*);

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R6", "unexpected sample", out_data, 0);
      end else begin
        logic [W-1:0] e;
        string t;
        e = q_data.pop_front();
        t = q_tag.pop_front();
        check(out_data == e, t, "data", out_data, e);
        check(out_index == exp_idx, "R4", "index", out_index, exp_idx);
        exp_idx++;
      end
    end
  end

  task automatic idle_gap(bit inv);
    for (int i = 0; i < 2 * W + 2; i++) begin
      @(negedge clk);
      fclk_inv = inv;
      fclk_bit = inv;
      lane_a = 1'b0;
      lane_b = 1'b0;
    end
    check(aligned == 1'b0, "R7", "aligned after gap", aligned, 0);
  endtask

  task automatic run_group(bit m2, bit lsb, bit inv, int n, int short_at);
    int cons = 0;
    bit prev_full = 1'b0;
    string tag;
    tag = m2 ? "R3/R2" : "R1/R2/R9";
    if (inv) tag = {tag, "/R5"};
    idle_gap(inv);
    mode_2w = m2;
    lsb_first = lsb;
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] wa, wb;
      int len;
      len = (k == short_at) ? W - 4 : W;
      wa = W'($urandom);
      wb = W'($urandom);
      if (k > 0 && prev_full) cons = (cons < 4) ? cons + 1 : 4;
      else cons = 0;
      if (len == W && k != n - 1) begin
        if (m2) begin
          q_data.push_back(wb); q_tag.push_back(tag);
          q_data.push_back(wa); q_tag.push_back(tag);
        end else begin
          q_data.push_back(wa); q_tag.push_back(tag);
        end
      end
      for (int b = 0; b < len; b++) begin
        @(negedge clk);
        if (b == W / 2)
          check(aligned == (cons >= 4), "R7", "aligned in frame", aligned, cons >= 4);
        fclk_bit = (b < W / 2) ^ inv;
        lane_a = lsb ? wa[b] : wa[W-1-b];
        lane_b = m2 ? (lsb ? wb[b] : wb[W-1-b]) : 1'($urandom);
      end
      prev_full = (len == W);
    end
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "valid after reset", out_valid, 0);
    check(aligned == 1'b0, "R8", "aligned after reset", aligned, 0);
    check(out_index == 16'd0, "R8", "index after reset", out_index, 0);
    run_group(1'b0, 1'b1, 1'b0, 7, -1);
    run_group(1'b0, 1'b0, 1'b0, 4, -1);
    run_group(1'b1, 1'b1, 1'b0, 7, -1);
    run_group(1'b1, 1'b0, 1'b1, 5, -1);
    run_group(1'b0, 1'b1, 1'b1, 11, 3);
    run_group(1'b1, 1'b1, 1'b0, 10, 5);
    idle_gap(1'b0);
    check(q_data.size() == 0, "R6", "samples left over", q_data.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule